// File: doc/BRIEF.md
# Flash Word Write Sequencer

This block sits between a byte-wide register bus and the program port of a word-addressed flash array. Software, or a DMA engine, writes bytes one at a time into a single data register. The block packs four of them into a 32-bit word and issues one program strobe for the word. It then waits for the array's completion flag and advances the word address by one. A session starts when software sets the write-enable bit in the control register. The session continues word after word until software clears that bit or a per-word time window runs out.

Each word has a window of `WIN_CYCLES` clocks to collect its four bytes. For the first word the window opens when the session starts. For later words it opens when the previous word's programming finishes. If the window closes before the fourth byte arrives, the session is aborted and the partial word is thrown away. The word address is kept, so software can enable the block again and resend the whole word. A single-cycle request line tells a DMA engine each time another byte can be taken. The DMA engine uses a fixed destination, byte-sized transfers and one transfer per request.

Top module: `fws_ctrl`

## Requirements
- R1: After reset the control register reads 0, both address bytes read 0, and `fl_prog` and `dma_req` are low.
- R2: The register map is selected by `reg_sel`.
  - Select 0 is the data register, which reads 0.
  - Select 1 is the control register: bit 0 is write-enable (read/write), bit 1 is software-busy (read-only) and bit 2 is busy (read-only).
  - Select 2 is the low byte of the word address, and select 3 holds the high address bits, read as 0 above `ADDR_W`.
  - `reg_rdata` shows the selected register one cycle after `reg_sel` is applied.
  - Address writes are ignored while busy is 1.
- R3: Writing the control register with bit 0 = 1 while busy is 0 starts a session: write-enable and busy become 1, and `dma_req` pulses in the next cycle.
- R4: Bytes fill the word least-significant first: byte 0 goes to bits 7:0 and byte 3 to bits 31:24. After the fourth byte, `fl_prog` pulses for one cycle with `fl_addr` equal to the word address and `fl_data` equal to the packed word. Software-busy stays 1 until `fl_done`.
- R5: Data bytes written while no session is active, or while software-busy is 1, are ignored.
- R6: On `fl_done`, software-busy clears and the word address increments by one. If write-enable is still set, a new window opens.
- R7: The fourth byte is accepted when it is written in any of the `WIN_CYCLES` cycles after the window opens. Otherwise the session ends with busy = write-enable = 0, no program strobe, and the word address unchanged.
- R8: After a timeout the partial word is discarded. Re-enabling and writing four new bytes programs the kept address with exactly those bytes.
- R9: Clearing write-enable while bytes are being collected ends the session at once and discards the partial word. Clearing it while a word is being programmed lets that word finish and the address advance, and then ends the session.
- R10: `dma_req` is a one-cycle pulse at session start, after each non-final byte, and at each `fl_done` that continues the session. This gives 4N+1 pulses for N words, and never while software-busy is 1 or the block is idle.
- R11: `fl_done` arriving while no word is being programmed has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data of the selected register |
| fl_addr | output | ADDR_W | Word address for programming |
| fl_data | output | 32 | Word to program |
| fl_prog | output | 1 | One-cycle program strobe |
| fl_done | input | 1 | Array signals that programming is complete |
| dma_req | output | 1 | One-cycle request for one more byte |

## Verification
A table of words is streamed through one continuous session: all zeros, all ones, and several asymmetric patterns. Each lane holds a different byte, so any swap in byte order or any lost byte shows up in the programmed data. Running them back to back also checks that the address steps once per word.

Directed sequences cover the window boundary:
- a fourth byte on the last allowed cycle;
- a fourth byte one cycle late;
- an abort while a partial word is pending, followed by a resend.

Further sequences cover the two places where write-enable can be cleared, stray bytes and stray completion flags, and address writes made while busy.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PROG    = 2'd2
  } seq_state_t;

  localparam logic [1:0] SEL_DATA    = 2'd0;
  localparam logic [1:0] SEL_CTRL    = 2'd1;
  localparam logic [1:0] SEL_ADDR_LO = 2'd2;
  localparam logic [1:0] SEL_ADDR_HI = 2'd3;

  localparam int CTRL_WEN_BIT    = 0;
  localparam int CTRL_SWBUSY_BIT = 1;
  localparam int CTRL_BUSY_BIT   = 2;

endpackage

// File: rtl/fws_byte_pack.sv
module fws_byte_pack #(
  parameter int BYTES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      push,
  input  logic [LANE_W-1:0]         din,
  output logic [BYTES*LANE_W-1:0]   word_o,
  output logic                      last_o
);
  localparam int CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTES - 1);

  logic [CNT_W-1:0] cnt_q;

  // lane fill counter, wraps after the final lane
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (push) begin
      if (cnt_q == LAST_IDX) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign last_o = push && (cnt_q == LAST_IDX);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    logic              hit;

    assign hit = push && (cnt_q == CNT_W'(g));

    always_ff @(posedge clk) begin
      if (rst || clr)  lane_q <= '0;
      else if (hit)    lane_q <= din;
    end

    // the word seen by the sequencer includes the byte arriving now
    assign word_o[g*LANE_W +: LANE_W] = hit ? din : lane_q;
  end

endmodule

// File: rtl/fws_win_timer.sv
module fws_win_timer #(
  parameter int WIN_CYCLES = 1280
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(WIN_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart)               cnt_q <= '0;
    else if (run && (cnt_q != LAST))  cnt_q <= cnt_q + TW'(1);
  end

  // high during the final cycle of the window
  assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/fws_seq.sv
module fws_seq
  import fws_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_wen,
  input  logic              byte_wr,
  input  logic              addr_lo_wr,
  input  logic              addr_hi_wr,
  input  logic [7:0]        wdata,
  input  logic [WORD_W-1:0] packed_word,
  input  logic              last_byte,
  input  logic              timeout,
  input  logic              fl_done,
  output logic              push_ok,
  output logic              pack_clr,
  output logic              tmr_restart,
  output logic              tmr_run,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [WORD_W-1:0] fl_data,
  output logic              fl_prog,
  output logic              dma_req,
  output logic              wen,
  output logic              swbusy,
  output logic              busy,
  output logic [ADDR_W-1:0] word_addr
);
  seq_state_t state_q;
  logic       start;
  logic       stop;
  logic       prog_end;
  logic [15:0] addr16_c;

  always_comb begin
    start       = (state_q == ST_IDLE) && ctrl_wr && ctrl_wen;
    stop        = ctrl_wr && !ctrl_wen;
    prog_end    = (state_q == ST_PROG) && fl_done;
    push_ok     = byte_wr && (state_q == ST_COLLECT);
    tmr_run     = (state_q == ST_COLLECT);
    tmr_restart = start || prog_end;
    pack_clr    = (state_q != ST_COLLECT) || stop || timeout;
  end

  always_comb begin
    addr16_c = 16'(word_addr);
    if (addr_lo_wr) addr16_c[7:0]  = wdata;
    if (addr_hi_wr) addr16_c[15:8] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      wen       <= 1'b0;
      swbusy    <= 1'b0;
      busy      <= 1'b0;
      word_addr <= '0;
      fl_addr   <= '0;
      fl_data   <= '0;
      fl_prog   <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      fl_prog <= 1'b0;
      dma_req <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_COLLECT;
            wen     <= 1'b1;
            busy    <= 1'b1;
            dma_req <= 1'b1;
          end else if (addr_lo_wr || addr_hi_wr) begin
            word_addr <= ADDR_W'(addr16_c);
          end
        end
        ST_COLLECT: begin
          if (stop) begin
            state_q <= ST_IDLE;
            wen     <= 1'b0;
            busy    <= 1'b0;
          end else if (last_byte) begin
            state_q <= ST_PROG;
            swbusy  <= 1'b1;
            fl_prog <= 1'b1;
            fl_addr <= word_addr;
            fl_data <= packed_word;
          end else if (timeout) begin
            state_q <= ST_IDLE;
            wen     <= 1'b0;
            busy    <= 1'b0;
          end else if (push_ok) begin
            dma_req <= 1'b1;
          end
        end
        ST_PROG: begin
          if (fl_done) begin
            swbusy    <= 1'b0;
            word_addr <= word_addr + ADDR_W'(1);
            if (wen && !stop) begin
              state_q <= ST_COLLECT;
              dma_req <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
              wen     <= 1'b0;
              busy    <= 1'b0;
            end
          end else if (stop) begin
            wen <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WIN_CYCLES = 1280,
  parameter int BYTES      = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            reg_sel,
  input  logic                  reg_wr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [BYTES*8-1:0]    fl_data,
  output logic                  fl_prog,
  input  logic                  fl_done,
  output logic                  dma_req
);
  localparam int WORD_W = BYTES * 8;

  logic              ctrl_wr, byte_wr, addr_lo_wr, addr_hi_wr;
  logic              push_ok, pack_clr, last_byte;
  logic              tmr_restart, tmr_run, timeout;
  logic [WORD_W-1:0] packed_word;
  logic              wen, swbusy, busy;
  logic [ADDR_W-1:0] word_addr;
  logic [15:0]       addr16;

  assign byte_wr    = reg_wr && (reg_sel == SEL_DATA);
  assign ctrl_wr    = reg_wr && (reg_sel == SEL_CTRL);
  assign addr_lo_wr = reg_wr && (reg_sel == SEL_ADDR_LO);
  assign addr_hi_wr = reg_wr && (reg_sel == SEL_ADDR_HI);

  fws_byte_pack #(.BYTES(BYTES), .LANE_W(8)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clr    (pack_clr),
    .push   (push_ok),
    .din    (reg_wdata),
    .word_o (packed_word),
    .last_o (last_byte)
  );

  fws_win_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .run     (tmr_run),
    .expired (timeout)
  );

  fws_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wen    (reg_wdata[CTRL_WEN_BIT]),
    .byte_wr     (byte_wr),
    .addr_lo_wr  (addr_lo_wr),
    .addr_hi_wr  (addr_hi_wr),
    .wdata       (reg_wdata),
    .packed_word (packed_word),
    .last_byte   (last_byte),
    .timeout     (timeout),
    .fl_done     (fl_done),
    .push_ok     (push_ok),
    .pack_clr    (pack_clr),
    .tmr_restart (tmr_restart),
    .tmr_run     (tmr_run),
    .fl_addr     (fl_addr),
    .fl_data     (fl_data),
    .fl_prog     (fl_prog),
    .dma_req     (dma_req),
    .wen         (wen),
    .swbusy      (swbusy),
    .busy        (busy),
    .word_addr   (word_addr)
  );

  assign addr16 = 16'(word_addr);

  // registered read-back of the selected register
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_sel)
        SEL_CTRL: begin
          reg_rdata[CTRL_WEN_BIT]    <= wen;
          reg_rdata[CTRL_SWBUSY_BIT] <= swbusy;
          reg_rdata[CTRL_BUSY_BIT]   <= busy;
        end
        SEL_ADDR_LO: reg_rdata <= addr16[7:0];
        SEL_ADDR_HI: reg_rdata <= addr16[15:8];
        default:     reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/fws_ctrl_chk.sv
module fws_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              fl_prog,
  input logic [ADDR_W-1:0] fl_addr,
  input logic              dma_req,
  input logic              swbusy,
  input logic              busy,
  input logic [ADDR_W-1:0] word_addr
);

  a_r4_prog_single: assert property (@(posedge clk) disable iff (rst)
    fl_prog |=> !fl_prog);

  a_r4_prog_in_swbusy: assert property (@(posedge clk) disable iff (rst)
    fl_prog |-> (swbusy && (fl_addr == word_addr)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
    $fell(swbusy) |-> (word_addr == ADDR_W'($past(word_addr) + 1'b1)));

  a_r7_swbusy_in_busy: assert property (@(posedge clk) disable iff (rst)
    swbusy |-> busy);

  a_r10_dma_when_open: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (busy && !swbusy));

  a_r2_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(swbusy)) |-> $stable(word_addr));

endmodule

bind fws_ctrl fws_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fl_prog   (fl_prog),
  .fl_addr   (fl_addr),
  .dma_req   (dma_req),
  .swbusy    (swbusy),
  .busy      (busy),
  .word_addr (word_addr)
);

// File: tb/fws_ctrl_tb.sv
module fws_ctrl_tb;
  import fws_pkg::*;

  localparam int ADDR_W = 10;
  localparam int WIN    = 16;
  localparam int LAT    = 3;
  localparam int NV     = 6;
  localparam logic [31:0] VEC [NV] = '{32'h00000000, 32'hFFFFFFFF, 32'h01234567,
                                       32'hA5A55A5A, 32'h80000001, 32'hDEADBEEF};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        reg_sel = '0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic [ADDR_W-1:0] fl_addr;
  logic [31:0]       fl_data;
  logic              fl_prog, fl_done, dma_req;
  logic              model_done = 1'b0, stray_done = 1'b0;

  logic [ADDR_W-1:0] last_addr = '0;
  logic [31:0]       last_data = '0;
  int                prog_cnt = 0, dma_cnt = 0, pend = 0;
  int                checks = 0, fails = 0;
  bit                ended = 0;

  always #5 clk = ~clk;

  assign fl_done = model_done | stray_done;

  fws_ctrl #(.ADDR_W(ADDR_W), .WIN_CYCLES(WIN), .BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_addr(fl_addr),
    .fl_data(fl_data), .fl_prog(fl_prog), .fl_done(fl_done), .dma_req(dma_req)
  );

  // behavioural flash array response and event counters
  always @(posedge clk) begin
    if (rst) begin
      pend <= 0; model_done <= 1'b0;
    end else begin
      if (fl_prog) begin
        last_addr <= fl_addr; last_data <= fl_data;
        prog_cnt  <= prog_cnt + 1; pend <= LAT;
      end else if (pend > 0) pend <= pend - 1;
      model_done <= (pend == 1);
      if (dma_req) dma_cnt <= dma_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s; reg_wr = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) wr(SEL_DATA, w[b*8 +: 8]);
  endtask

  task automatic wait_done();
    logic [7:0] v;
    for (int k = 0; k < 40; k++) begin
      rd(SEL_CTRL, v);
      if (!v[CTRL_SWBUSY_BIT]) break;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int p0, d0;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 fl_prog", 32'(fl_prog), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    rd(SEL_CTRL, v);    chk("R1 ctrl", 32'(v), 0);
    rd(SEL_ADDR_LO, v); chk("R1 addr_lo", 32'(v), 0);
    rd(SEL_ADDR_HI, v); chk("R1 addr_hi", 32'(v), 0);

    // R2 address register read-back
    wr(SEL_ADDR_LO, 8'h34); wr(SEL_ADDR_HI, 8'h02);
    rd(SEL_ADDR_LO, v); chk("R2 addr_lo", 32'(v), 32'h34);
    rd(SEL_ADDR_HI, v); chk("R2 addr_hi", 32'(v), 32'h02);
    rd(SEL_DATA, v);    chk("R2 data reads zero", 32'(v), 0);

    // vector table through one session at base 0x105
    wr(SEL_ADDR_LO, 8'h05); wr(SEL_ADDR_HI, 8'h01);
    wr(SEL_DATA, 8'hAA); wr(SEL_DATA, 8'hBB);   // R5 stray bytes while idle
    p0 = prog_cnt; d0 = dma_cnt;
    wr(SEL_CTRL, 8'h01);
    chk("R3 dma_req at start", 32'(dma_req), 1);
    rd(SEL_CTRL, v); chk("R3 ctrl after start", 32'(v), 32'h05);
    for (int i = 0; i < NV; i++) begin
      put_word(VEC[i]);
      if (i == 0) wr(SEL_DATA, 8'hCC);           // R5 byte while programming
      wait_done();
      chk("R4 packed data", last_data, VEC[i]);
      chk("R6 word address", 32'(last_addr), 32'h105 + 32'(i));
    end
    wr(SEL_CTRL, 8'h00);
    rd(SEL_CTRL, v);    chk("R9 stop between words", 32'(v), 0);
    rd(SEL_ADDR_LO, v); chk("R6 final addr", 32'(v), 32'h0B);
    chk("R5 program count", 32'(prog_cnt - p0), NV);
    chk("R10 dma pulses", 32'(dma_cnt - d0), 4*NV + 1);

    // R7 fourth byte on the last window cycle
    wr(SEL_ADDR_LO, 8'h40); wr(SEL_ADDR_HI, 8'h00);
    wr(SEL_CTRL, 8'h01);
    wr(SEL_DATA, 8'h44); wr(SEL_DATA, 8'h33); wr(SEL_DATA, 8'h22);
    idle(WIN - 4);
    wr(SEL_DATA, 8'h11);
    wait_done();
    chk("R7 last-cycle byte data", last_data, 32'h11223344);
    chk("R7 last-cycle byte addr", 32'(last_addr), 32'h40);
    wr(SEL_ADDR_LO, 8'h99);                     // R2 ignored while busy
    wr(SEL_CTRL, 8'h00);
    rd(SEL_ADDR_LO, v); chk("R2 addr write while busy", 32'(v), 32'h41);

    // R7 fourth byte one cycle late
    p0 = prog_cnt;
    wr(SEL_CTRL, 8'h01);
    wr(SEL_DATA, 8'h88); wr(SEL_DATA, 8'h77); wr(SEL_DATA, 8'h66);
    idle(WIN - 3);
    wr(SEL_DATA, 8'h55);
    idle(LAT + 3);
    chk("R7 no program after timeout", 32'(prog_cnt - p0), 0);
    rd(SEL_CTRL, v);    chk("R7 ctrl after timeout", 32'(v), 0);
    rd(SEL_ADDR_LO, v); chk("R7 addr kept", 32'(v), 32'h41);

    // R8 resend after timeout with a partial word pending
    wr(SEL_CTRL, 8'h01);
    wr(SEL_DATA, 8'hE1); wr(SEL_DATA, 8'hE2);
    idle(WIN + 2);
    wr(SEL_CTRL, 8'h01);
    put_word(32'hCAFEF00D);
    wait_done();
    chk("R8 resend data", last_data, 32'hCAFEF00D);
    chk("R8 resend addr", 32'(last_addr), 32'h41);
    wr(SEL_CTRL, 8'h00);

    // R9 clear while collecting
    p0 = prog_cnt;
    wr(SEL_CTRL, 8'h01);
    wr(SEL_DATA, 8'h12); wr(SEL_DATA, 8'h34);
    wr(SEL_CTRL, 8'h00);
    rd(SEL_CTRL, v); chk("R9 ctrl after clear", 32'(v), 0);
    chk("R9 no program", 32'(prog_cnt - p0), 0);
    wr(SEL_CTRL, 8'h01);
    put_word(32'h0BADC0DE);
    wait_done();
    chk("R9 partial discarded", last_data, 32'h0BADC0DE);
    chk("R9 addr", 32'(last_addr), 32'h42);

    // R9 clear while programming
    put_word(32'h600DF00D);
    wr(SEL_CTRL, 8'h00);
    wait_done();
    idle(1);
    rd(SEL_CTRL, v);    chk("R9 ctrl after finish", 32'(v), 0);
    chk("R9 word completed", last_data, 32'h600DF00D);
    rd(SEL_ADDR_LO, v); chk("R9 addr advanced", 32'(v), 32'h44);

    // R11 stray completion while idle
    stray_done = 1'b1; idle(1); stray_done = 1'b0;
    idle(1);
    rd(SEL_ADDR_LO, v); chk("R11 addr unchanged", 32'(v), 32'h44);
    rd(SEL_CTRL, v);    chk("R11 ctrl unchanged", 32'(v), 0);

    finish_run();
  end

endmodule